// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects the interrupt causes of a packet network controller into one 8-bit status register, qualifies them with an 8-bit enable mask, and drives a single level-sensitive interrupt line toward the host. Event pulses arrive from the packet engine: allocation done, frame received and receive overrun. Two bits are also forced on from live queue levels on every cycle: transmit-empty while the transmit queue holds nothing, and transmit-done while the completion queue still holds entries.

Software reaches the block through a small byte-wide register port. Selector 0 reads the status register, and a write to it acts as a write-one-to-clear acknowledge. Only a fixed subset of the bits can be acknowledged this way. The receive and allocation bits are cleared by engine-side pulses instead. Selector 1 reads and writes the mask. An acknowledge that names the transmit-done bit also sends one pop request to the external completion queue, in the same cycle as the write.

Top module: `isc_ctrl`

## Requirements
- R1: Status bit positions are bit 7 management, bit 6 early-receive, bit 5 PHY event, bit 4 receive overrun, bit 3 allocation done, bit 2 transmit empty, bit 1 transmit done, bit 0 receive. A pulse on ev_alloc, ev_rx or ev_rx_ovr sets bit 3, 0 or 4 on the next clock edge. The status register is read at reg_sel 0.
- R2: irq is a register. After each clock edge it equals the OR of (status AND mask) as they stood before that edge, so it follows any status or mask change one cycle later.
- R3: A write at reg_sel 0 clears exactly those status bits that are 1 both in reg_wdata and in 0xD6 (bits 7, 6, 4, 2, 1). Bits 5, 3 and 0 are not affected by it.
- R4: A write at reg_sel 0 with reg_wdata bit 1 set drives cq_pop high for that one cycle. No other access drives cq_pop.
- R5: On every clock edge where txq_len is zero, status bit 2 becomes 1.
- R6: On every clock edge, status bit 1 becomes 1 if cq_cnt, less one when cq_pop is high and cq_cnt is nonzero, is still nonzero.
- R7: After reset the status register reads 0x04, the mask reads 0x00 and irq is low.
- R8: A write at reg_sel 1 loads the mask, and the mask reads back at reg_sel 1 after the next edge.
- R9: When a set source (event pulse or level) and a clear (acknowledge or engine clear) hit the same bit in the same cycle, the bit ends up set.
- R10: A pulse on clr_alloc clears status bit 3, and a pulse on clr_rx clears status bit 0.
- R11: Writes at reg_sel 2 and 3 change neither the status nor the mask, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 status/ack, 1 mask, 2-3 reserved |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ev_alloc | input | 1 | Allocation-done event pulse |
| ev_rx | input | 1 | Frame-received event pulse |
| ev_rx_ovr | input | 1 | Receive-overrun event pulse |
| clr_alloc | input | 1 | Engine clear of the allocation-done bit |
| clr_rx | input | 1 | Engine clear of the receive bit |
| txq_len | input | CNT_W | Current transmit queue length |
| cq_cnt | input | CNT_W | Current completion queue entry count |
| cq_pop | output | 1 | Pop request to the completion queue |
| irq | output | 1 | Registered interrupt line |

## Verification
Acknowledge writes are tried with all ones, all zeros and single bits. All ones shows that bits outside 0xD6 survive, and all zeros shows that a write alone clears nothing. The transmit-done level is driven with counts of 2, 1 and 0 together with a pop. This shows whether the block uses the count left after the pop or the stale count. Set-against-clear collisions are staged for both an event against an acknowledge and an event against an engine clear. Mask changes are timed against irq, so an unregistered or doubly registered output shows up as an off-by-one cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int NBITS = 8;
  localparam int SEL_W = 2;

  localparam int B_RX      = 0;
  localparam int B_TXDONE  = 1;
  localparam int B_TXEMPTY = 2;
  localparam int B_ALLOC   = 3;
  localparam int B_OVR     = 4;
  localparam int B_PHY     = 5;
  localparam int B_ERX     = 6;
  localparam int B_MGMT    = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } sel_e;

  // one-hot vector with bit idx equal to v
  function automatic logic [NBITS-1:0] place(input int idx, input logic v);
    logic [NBITS-1:0] r;
    r = '0;
    r[idx] = v;
    return r;
  endfunction

  // set sources dominate; clears only act on bits allowed to clear
  function automatic logic next_bit(input logic cur, input logic set,
                                    input logic ack, input logic ackable,
                                    input logic eclr);
    return set | (cur & ~(ack & ackable) & ~eclr);
  endfunction

  // is the queue still non-empty once this cycle's pop is taken out
  function automatic logic left_after_pop(input int unsigned cnt, input logic pop);
    if (pop && cnt != 0) return (cnt - 1) != 0;
    return cnt != 0;
  endfunction

endpackage

// File: rtl/isc_regport.sv
module isc_regport
  import isc_pkg::*;
(
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [NBITS-1:0] reg_wdata,
  input  logic [NBITS-1:0] status_q,
  input  logic [NBITS-1:0] mask_q,
  output logic [NBITS-1:0] ack_bits,
  output logic             mask_we,
  output logic [NBITS-1:0] mask_wdata,
  output logic             pop_req,
  output logic [NBITS-1:0] reg_rdata
);

  logic stat_wr;

  always_comb begin
    stat_wr    = reg_wr && (sel_e'(reg_sel) == SEL_STAT);
    mask_we    = reg_wr && (sel_e'(reg_sel) == SEL_MASK);
    ack_bits   = stat_wr ? reg_wdata : '0;
    mask_wdata = reg_wdata;
    pop_req    = stat_wr && reg_wdata[B_TXDONE];
  end

  always_comb begin
    case (sel_e'(reg_sel))
      SEL_STAT: reg_rdata = status_q;
      SEL_MASK: reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/isc_status.sv
module isc_status
  import isc_pkg::*;
#(
  parameter int               CNT_W    = 3,
  parameter logic [NBITS-1:0] ACK_MASK = 8'hD6,
  parameter logic [NBITS-1:0] RST_VAL  = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_alloc,
  input  logic             ev_rx,
  input  logic             ev_rx_ovr,
  input  logic             clr_alloc,
  input  logic             clr_rx,
  input  logic [CNT_W-1:0] txq_len,
  input  logic [CNT_W-1:0] cq_cnt,
  input  logic [NBITS-1:0] ack_bits,
  input  logic             pop_req,
  output logic [NBITS-1:0] status_q
);

  logic             txq_empty;
  logic             cq_left;
  logic [NBITS-1:0] set_vec;
  logic [NBITS-1:0] eclr_vec;
  logic [NBITS-1:0] nxt;

  always_comb begin
    txq_empty = (txq_len == '0);
    cq_left   = left_after_pop(32'(cq_cnt), pop_req);
    set_vec   = place(B_ALLOC, ev_alloc) | place(B_RX, ev_rx) |
                place(B_OVR, ev_rx_ovr) | place(B_TXEMPTY, txq_empty) |
                place(B_TXDONE, cq_left);
    eclr_vec  = place(B_ALLOC, clr_alloc) | place(B_RX, clr_rx);
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign nxt[i] = next_bit(status_q[i], set_vec[i], ack_bits[i],
                             ACK_MASK[i], eclr_vec[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= RST_VAL[i];
      else        status_q[i] <= nxt[i];
    end
  end

  // R5: an empty transmit queue forces its bit
  a_r5_txempty_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_len == '0) |=> status_q[B_TXEMPTY]);

  // R6: more than one completion left survives any single pop
  a_r6_txdone_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_cnt > 1) |=> status_q[B_TXDONE]);

  // R9: event pulse beats a simultaneous acknowledge
  a_r9_ovr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ovr |=> status_q[B_OVR]);

  // R9: event pulse beats a simultaneous engine clear
  a_r9_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> status_q[B_RX]);

  // R3: acknowledge cannot drop the allocation bit
  a_r3_alloc_unackable: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_ALLOC] && !clr_alloc) |=> status_q[B_ALLOC]);

  // R3: acknowledge of the overrun bit clears it when no new event arrives
  a_r3_ovr_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits[B_OVR] && !ev_rx_ovr) |=> !status_q[B_OVR]);

  // R10: engine clear drops the receive bit when no new event arrives
  a_r10_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx && !ev_rx) |=> !status_q[B_RX]);

endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_wdata,
  input  logic [NBITS-1:0] status_q,
  output logic [NBITS-1:0] mask_q,
  output logic             irq
);

  logic pending;

  always_comb pending = |(status_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq <= pending;
    end
  end

  // R2: an enabled status bit raises irq one edge later
  a_r2_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) != '0) |=> irq);

  // R8: a fully masked controller keeps irq low on the next edge
  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ev_alloc,
  input  logic             ev_rx,
  input  logic             ev_rx_ovr,
  input  logic             clr_alloc,
  input  logic             clr_rx,
  input  logic [CNT_W-1:0] txq_len,
  input  logic [CNT_W-1:0] cq_cnt,
  output logic             cq_pop,
  output logic             irq
);

  logic [NBITS-1:0] status_q;
  logic [NBITS-1:0] mask_q;
  logic [NBITS-1:0] ack_bits;
  logic             mask_we;
  logic [NBITS-1:0] mask_wdata;
  logic             pop_req;

  isc_regport u_port (
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .ack_bits   (ack_bits),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .pop_req    (pop_req),
    .reg_rdata  (reg_rdata)
  );

  isc_status #(
    .CNT_W    (CNT_W),
    .ACK_MASK (8'hD6),
    .RST_VAL  (8'h04)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_alloc  (ev_alloc),
    .ev_rx     (ev_rx),
    .ev_rx_ovr (ev_rx_ovr),
    .clr_alloc (clr_alloc),
    .clr_rx    (clr_rx),
    .txq_len   (txq_len),
    .cq_cnt    (cq_cnt),
    .ack_bits  (ack_bits),
    .pop_req   (pop_req),
    .status_q  (status_q)
  );

  isc_irq_out u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .irq        (irq)
  );

  assign cq_pop = pop_req;

  // R4: a pop only comes from a status write naming transmit-done
  a_r4_pop_source: assert property (@(posedge clk) disable iff (!rst_n)
    cq_pop |-> (reg_wr && reg_sel == 2'd0 && reg_wdata[1]));

endmodule

// File: tb/sim_isc_ctrl.sv
`timescale 1ns/1ps
module sim_isc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ev_alloc = 1'b0, ev_rx = 1'b0, ev_rx_ovr = 1'b0;
  logic       clr_alloc = 1'b0, clr_rx = 1'b0;
  logic [2:0] txq_len = 3'd1;
  logic [2:0] cq_cnt = 3'd0;
  logic       cq_pop;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  isc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_alloc(ev_alloc),
    .ev_rx(ev_rx), .ev_rx_ovr(ev_rx_ovr), .clr_alloc(clr_alloc),
    .clr_rx(clr_rx), .txq_len(txq_len), .cq_cnt(cq_cnt),
    .cq_pop(cq_pop), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // advance one edge, then sit 1 ns past it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    reg_wr = 0; ev_alloc = 0; ev_rx = 0; ev_rx_ovr = 0;
    clr_alloc = 0; clr_rx = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R7 status after reset", v, 8'h04);
    rd(2'd1, v); chk("R7 mask after reset", v, 8'h00);
    chk("R7 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_events_and_ack();
    logic [7:0] v;
    ev_alloc = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R1 alloc sets bit 3", v, 8'h0C);
    ev_rx = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R1 rx sets bit 0", v, 8'h0D);
    ev_rx_ovr = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R1 overrun sets bit 4", v, 8'h1D);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R3 zero ack clears nothing", v, 8'h1D);
    reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'hFF; #1;
    chk("R4 pop during ack with bit 1", {7'd0, cq_pop}, 8'h01);
    tick(); reg_wr = 0; #1;
    chk("R4 pop is one cycle", {7'd0, cq_pop}, 8'h00);
    rd(2'd0, v); chk("R3 ack 0xFF keeps bits 3 and 0", v, 8'h09);
  endtask

  task automatic t_engine_clear();
    logic [7:0] v;
    clr_alloc = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R10 clr_alloc drops bit 3", v, 8'h01);
    clr_rx = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R10 clr_rx drops bit 0", v, 8'h00);
  endtask

  task automatic t_txempty();
    logic [7:0] v;
    txq_len = 3'd0; tick(); txq_len = 3'd1;
    rd(2'd0, v); chk("R5 empty queue sets bit 2", v, 8'h04);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R5 bit 2 acked while queue busy", v, 8'h00);
  endtask

  task automatic t_txdone();
    logic [7:0] v;
    cq_cnt = 3'd2; tick();
    rd(2'd0, v); chk("R6 completions set bit 1", v, 8'h02);
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R6 two left minus pop keeps bit 1", v, 8'h02);
    cq_cnt = 3'd1;
    wr(2'd0, 8'h02);
    cq_cnt = 3'd0;
    rd(2'd0, v); chk("R6 last entry popped clears bit 1", v, 8'h00);
    tick();
    rd(2'd0, v); chk("R6 empty queue leaves bit 1 low", v, 8'h00);
  endtask

  task automatic t_mask_irq();
    logic [7:0] v;
    ev_rx = 1; tick(); idle_inputs();
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R8 mask reads back", v, 8'h01);
    chk("R2 irq not yet high", {7'd0, irq}, 8'h00);
    tick();
    chk("R2 irq high one cycle later", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    chk("R2 irq lags mask clear", {7'd0, irq}, 8'h01);
    tick();
    chk("R8 irq low after mask clear", {7'd0, irq}, 8'h00);
    clr_rx = 1; tick(); idle_inputs();
  endtask

  task automatic t_collisions();
    logic [7:0] v;
    ev_rx = 1; clr_rx = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R9 rx event beats engine clear", v, 8'h01);
    ev_rx_ovr = 1; wr(2'd0, 8'h10); idle_inputs();
    rd(2'd0, v); chk("R9 overrun beats ack", v, 8'h11);
    wr(2'd0, 8'h10);
    clr_rx = 1; tick(); idle_inputs();
    rd(2'd0, v); chk("R3 ack after collision clears", v, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    ev_alloc = 1; tick(); idle_inputs();
    wr(2'd1, 8'h08);
    reg_wr = 1; reg_sel = 2'd2; reg_wdata = 8'hFF; #1;
    chk("R11 no pop on reserved write", {7'd0, cq_pop}, 8'h00);
    tick(); reg_sel = 2'd3; tick(); reg_wr = 0;
    rd(2'd2, v); chk("R11 reserved read 2", v, 8'h00);
    rd(2'd3, v); chk("R11 reserved read 3", v, 8'h00);
    rd(2'd1, v); chk("R11 mask unchanged", v, 8'h08);
    rd(2'd0, v); chk("R11 status unchanged", v, 8'h08);
    chk("R2 enabled alloc bit drives irq", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    #200_000_0;
    n_err++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    #1;
    t_reset();
    t_events_and_ack();
    t_engine_clear();
    t_txempty();
    t_txdone();
    t_mask_irq();
    t_collisions();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule